// File: doc/BRIEF.md
# Task Register Loader

This block carries out the load of the task register in a protected-mode core. A 16-bit selector is presented on a request port. The block locates the eight-byte descriptor that the selector names, reads it over a single-ported descriptor-table interface and decides whether it describes a task-state segment that is not already in use. When that holds, the selector goes into the visible half of the task register, and base, limit and privilege level go into the hidden half. The same descriptor is then written back with its busy flag raised, so that a second load of the same task is refused.

A refused load leaves the task register and the table untouched. It reports one of three general-protection causes, together with an error code built from the selector. Every request ends with a single-cycle `done_o` pulse and a 2-bit result. The block holds `busy_o` high while it works, and it drops any request it sees in that time.

Top module: `trl_loader`

## Requirements
- R1: The table entry is chosen by selector bit 2 (1 = local table, 0 = global table) and index `sel[15:3]`. Each entry is 8 bytes. Read data is taken one cycle after `tbl_rd_en_o`.
- R2: A selector is out of range, and gives status 01 without any table read, in two cases: when `{index,3'b111}` exceeds the limit of the chosen table, or when it is a null global selector (index 0 with bit 2 clear). `done_o` follows 1 cycle after the accepting edge.
- R3: A descriptor whose S bit (bit 44) is 1, or whose type (bits 43:40) is not 0001, 0011, 1001 or 1011, gives status 10 with `done_o` 3 cycles after acceptance.
- R4: A task-state descriptor with type bit 41 set (busy) gives status 11 with `done_o` 3 cycles after acceptance.
- R5: An available task-state descriptor gives status 00 with `done_o` 4 cycles after acceptance. The task register then holds the selector, base `{d[63:56],d[39:16]}`, limit `{d[51:48],d[15:0]}` and privilege level `d[46:45]`.
- R6: After a successful check, the same entry is written once with bit 41 set and every other bit unchanged. The write happens in the cycle before the `done_o` pulse.
- R7: A refused load writes nothing to the table and leaves every task-register output unchanged.
- R8: `done_o` is high for exactly one cycle per accepted request. `fault_code_o` equals the selector with its two low bits cleared on a fault, and 0 on success.
- R9: A request seen while `busy_o` is high is dropped: it causes no table access and no `done_o`, and the table is not touched for it.
- R10: Reset clears the task register to zero and drives `done_o` and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Load request, taken when idle |
| req_sel_i | input | 16 | Selector to load |
| busy_o | output | 1 | A load is in progress |
| gtab_limit_i | input | 16 | Byte limit of the global table |
| ltab_limit_i | input | 16 | Byte limit of the local table |
| tbl_rd_en_o | output | 1 | Descriptor read strobe |
| tbl_local_o | output | 1 | Table select for read and write (1 = local) |
| tbl_idx_o | output | 13 | Entry index for read and write |
| tbl_rd_data_i | input | 64 | Descriptor read data, one cycle after the strobe |
| tbl_wr_en_o | output | 1 | Descriptor write-back strobe |
| tbl_wr_data_o | output | 64 | Descriptor with busy flag set |
| tr_sel_o | output | 16 | Visible task-register selector |
| tr_base_o | output | 32 | Hidden base |
| tr_limit_o | output | 20 | Hidden limit |
| tr_dpl_o | output | 2 | Hidden privilege level |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ok, 01 range, 10 not a task segment, 11 busy |
| fault_code_o | output | 16 | Error code on fault, 0 on success |

## Verification
Two functions can fall in the same cycle: the busy write-back that closes one load, and the arrival of the next request. The bench holds a second request high through every working cycle of a load, the write-back cycle included. It then checks that only one completion appears and that the selector it carried was never read or marked. Straight after that completion it loads the just-accepted selector again. A busy refusal (status 11) there shows that the write-back reached the table before the next read.

// File: rtl/trl_pkg.sv
package trl_pkg;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = SEL_W - 3;
  localparam int DESC_W  = 64;
  localparam int BASE_W  = 32;
  localparam int LIM_W   = 20;
  localparam int TYPE_W  = 4;

  // descriptor field positions (fixed by the table format)
  localparam int LIM_LO_LSB  = 0;
  localparam int BASE_LO_LSB = 16;
  localparam int TYPE_LSB    = 40;
  localparam int SBIT_POS    = 44;
  localparam int DPL_LSB     = 45;
  localparam int LIM_HI_LSB  = 48;
  localparam int BASE_HI_LSB = 56;
  localparam int BUSY_POS    = TYPE_LSB + 1;
  localparam int TI_POS      = 2;
  localparam int IDX_LSB     = 3;

  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_RANGE    = 2'b01,
    ST_NOT_TASK = 2'b10,
    ST_BUSY     = 2'b11
  } ld_status_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOOKUP, PH_FETCH, PH_CHECK, PH_COMMIT
  } ld_phase_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [1:0]        dpl;
  } tr_hidden_t;

  function automatic logic [TYPE_W-1:0] dsc_type(input logic [DESC_W-1:0] d);
    return d[TYPE_LSB +: TYPE_W];
  endfunction

  function automatic logic dsc_is_sys(input logic [DESC_W-1:0] d);
    return ~d[SBIT_POS];
  endfunction

  function automatic logic [BASE_W-1:0] dsc_base(input logic [DESC_W-1:0] d);
    return {d[BASE_HI_LSB +: 8], d[BASE_LO_LSB +: 24]};
  endfunction

  function automatic logic [LIM_W-1:0] dsc_limit(input logic [DESC_W-1:0] d);
    return {d[LIM_HI_LSB +: 4], d[LIM_LO_LSB +: 16]};
  endfunction

  function automatic logic [1:0] dsc_dpl(input logic [DESC_W-1:0] d);
    return d[DPL_LSB +: 2];
  endfunction

  function automatic logic [DESC_W-1:0] dsc_mark_busy(input logic [DESC_W-1:0] d);
    logic [DESC_W-1:0] r;
    r = d;
    r[BUSY_POS] = 1'b1;
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:IDX_LSB];
  endfunction

  function automatic logic sel_local(input logic [SEL_W-1:0] s);
    return s[TI_POS];
  endfunction

  // offset of the last byte of an 8-byte entry
  function automatic logic [SEL_W-1:0] entry_end(input logic [IDX_W-1:0] idx);
    return {idx, 3'b111};
  endfunction

  function automatic logic [SEL_W-1:0] gp_code(input logic [SEL_W-1:0] s);
    return {s[SEL_W-1:TI_POS], 2'b00};
  endfunction
endpackage

// File: rtl/trl_range_gate.sv
module trl_range_gate
  import trl_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] gtab_limit_i,
  input  logic [SEL_W-1:0] ltab_limit_i,
  output logic             null_o,
  output logic             range_ok_o
);
  logic [SEL_W-1:0] lim_w;
  logic [SEL_W-1:0] end_w;

  always_comb begin
    lim_w      = sel_local(sel_i) ? ltab_limit_i : gtab_limit_i;
    end_w      = entry_end(sel_index(sel_i));
    null_o     = !sel_local(sel_i) && (sel_index(sel_i) == '0);
    range_ok_o = (end_w <= lim_w) && !null_o;
  end
endmodule

// File: rtl/trl_desc_check.sv
module trl_desc_check
  import trl_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output logic              is_task_o,
  output logic              is_busy_o
);
  logic [TYPE_W-1:0] ty_w;

  // accepted type codes: x0x1 with bit 3 = width and bit 1 = busy
  always_comb begin
    ty_w      = dsc_type(desc_i);
    is_task_o = dsc_is_sys(desc_i) && ty_w[0] && !ty_w[2];
    is_busy_o = ty_w[1];
  end
endmodule

// File: rtl/trl_fsm.sv
module trl_fsm
  import trl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic       range_ok_i,
  input  logic       is_task_i,
  input  logic       is_busy_i,
  output logic       busy_o,
  output logic       accept_o,
  output logic       rd_en_o,
  output logic       capture_o,
  output logic       commit_o,
  output logic       wr_en_o,
  output logic       fault_o,
  output logic       done_o,
  output logic [1:0] status_o
);
  ld_phase_e  ph_q, ph_n;
  ld_status_e st_q, st_n;
  logic       done_q;
  logic       range_fault_w, type_fault_w, busy_fault_w;

  always_comb begin
    ph_n = ph_q;
    case (ph_q)
      PH_IDLE:   if (req_valid_i) ph_n = PH_LOOKUP;
      PH_LOOKUP: ph_n = range_ok_i ? PH_FETCH : PH_IDLE;
      PH_FETCH:  ph_n = PH_CHECK;
      PH_CHECK:  ph_n = (is_task_i && !is_busy_i) ? PH_COMMIT : PH_IDLE;
      PH_COMMIT: ph_n = PH_IDLE;
      default:   ph_n = PH_IDLE;
    endcase
  end

  always_comb begin
    busy_o        = (ph_q != PH_IDLE);
    accept_o      = (ph_q == PH_IDLE) && req_valid_i;
    rd_en_o       = (ph_q == PH_LOOKUP) && range_ok_i;
    capture_o     = (ph_q == PH_FETCH);
    commit_o      = (ph_q == PH_CHECK) && is_task_i && !is_busy_i;
    wr_en_o       = (ph_q == PH_COMMIT);
    range_fault_w = (ph_q == PH_LOOKUP) && !range_ok_i;
    type_fault_w  = (ph_q == PH_CHECK) && !is_task_i;
    busy_fault_w  = (ph_q == PH_CHECK) && is_task_i && is_busy_i;
    fault_o       = range_fault_w || type_fault_w || busy_fault_w;
    if (range_fault_w)     st_n = ST_RANGE;
    else if (type_fault_w) st_n = ST_NOT_TASK;
    else if (busy_fault_w) st_n = ST_BUSY;
    else                   st_n = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      st_q   <= ST_OK;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      done_q <= fault_o || wr_en_o;
      if (fault_o || wr_en_o) st_q <= st_n;
    end
  end

  assign done_o   = done_q;
  assign status_o = st_q;
endmodule

// File: rtl/trl_taskreg.sv
module trl_taskreg
  import trl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic [SEL_W-1:0]  sel_o,
  output tr_hidden_t        hid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o <= '0;
      hid_o <= '0;
    end else if (load_i) begin
      sel_o       <= sel_i;
      hid_o.base  <= dsc_base(desc_i);
      hid_o.limit <= dsc_limit(desc_i);
      hid_o.dpl   <= dsc_dpl(desc_i);
    end
  end
endmodule

// File: rtl/trl_loader.sv
module trl_loader
  import trl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  output logic              busy_o,
  input  logic [SEL_W-1:0]  gtab_limit_i,
  input  logic [SEL_W-1:0]  ltab_limit_i,
  output logic              tbl_rd_en_o,
  output logic              tbl_local_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  input  logic [DESC_W-1:0] tbl_rd_data_i,
  output logic              tbl_wr_en_o,
  output logic [DESC_W-1:0] tbl_wr_data_o,
  output logic [SEL_W-1:0]  tr_sel_o,
  output logic [BASE_W-1:0] tr_base_o,
  output logic [LIM_W-1:0]  tr_limit_o,
  output logic [1:0]        tr_dpl_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [SEL_W-1:0]  fault_code_o
);
  // named internal events, visible to the bound checker
  logic              accept_w, capture_w, commit_w, fault_w;
  logic              range_ok_w, null_w, is_task_w, is_busy_w;
  logic [SEL_W-1:0]  sel_q;
  logic [DESC_W-1:0] desc_q;
  logic [SEL_W-1:0]  fcode_q;
  tr_hidden_t        hid_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      desc_q  <= '0;
      fcode_q <= '0;
    end else begin
      if (accept_w)  sel_q  <= req_sel_i;
      if (capture_w) desc_q <= tbl_rd_data_i;
      if (fault_w)          fcode_q <= gp_code(sel_q);
      else if (tbl_wr_en_o) fcode_q <= '0;
    end
  end

  trl_range_gate u_range (
    .sel_i        (sel_q),
    .gtab_limit_i (gtab_limit_i),
    .ltab_limit_i (ltab_limit_i),
    .null_o       (null_w),
    .range_ok_o   (range_ok_w)
  );

  trl_desc_check u_dchk (
    .desc_i    (desc_q),
    .is_task_o (is_task_w),
    .is_busy_o (is_busy_w)
  );

  trl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .range_ok_i  (range_ok_w),
    .is_task_i   (is_task_w),
    .is_busy_i   (is_busy_w),
    .busy_o      (busy_o),
    .accept_o    (accept_w),
    .rd_en_o     (tbl_rd_en_o),
    .capture_o   (capture_w),
    .commit_o    (commit_w),
    .wr_en_o     (tbl_wr_en_o),
    .fault_o     (fault_w),
    .done_o      (done_o),
    .status_o    (status_o)
  );

  trl_taskreg u_tr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (commit_w),
    .sel_i  (sel_q),
    .desc_i (desc_q),
    .sel_o  (tr_sel_o),
    .hid_o  (hid_w)
  );

  assign tbl_local_o   = sel_local(sel_q);
  assign tbl_idx_o     = sel_index(sel_q);
  assign tbl_wr_data_o = dsc_mark_busy(desc_q);
  assign tr_base_o     = hid_w.base;
  assign tr_limit_o    = hid_w.limit;
  assign tr_dpl_o      = hid_w.dpl;
  assign fault_code_o  = fcode_q;
endmodule

// File: rtl/trl_loader_sva.sv
module trl_loader_sva
  import trl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              tbl_rd_en_o,
  input logic              tbl_wr_en_o,
  input logic [DESC_W-1:0] tbl_wr_data_o,
  input logic [SEL_W-1:0]  tr_sel_o,
  input logic [BASE_W-1:0] tr_base_o,
  input logic [LIM_W-1:0]  tr_limit_o,
  input logic [1:0]        tr_dpl_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic              null_w
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done held"); // R8

  AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 2'b01) |-> !$past(tbl_rd_en_o)) else $error("read on range fault"); // R2

  AST_NULL_NEVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    null_w |-> !tbl_rd_en_o) else $error("null selector read"); // R2

  AST_FAULT_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 2'b00) |-> ($stable(tr_sel_o) && $stable(tr_base_o)
      && $stable(tr_limit_o) && $stable(tr_dpl_o))) else $error("TR moved on fault"); // R7

  AST_WB_BUSY_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en_o |-> (tbl_wr_data_o[BUSY_POS] && !tbl_wr_data_o[SBIT_POS])) else $error("bad write-back"); // R6

  AST_WB_THEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en_o |=> (done_o && status_o == 2'b00)) else $error("write-back without ok"); // R6

  AST_WB_MATCH_TR: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en_o |-> (tr_base_o == dsc_base(tbl_wr_data_o) && tr_limit_o == dsc_limit(tbl_wr_data_o)
      && tr_dpl_o == dsc_dpl(tbl_wr_data_o))) else $error("TR hidden mismatch"); // R5

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tbl_rd_en_o && !tbl_wr_en_o)) else $error("access while idle"); // R9
endmodule

bind trl_loader trl_loader_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .tbl_rd_en_o   (tbl_rd_en_o),
  .tbl_wr_en_o   (tbl_wr_en_o),
  .tbl_wr_data_o (tbl_wr_data_o),
  .tr_sel_o      (tr_sel_o),
  .tr_base_o     (tr_base_o),
  .tr_limit_o    (tr_limit_o),
  .tr_dpl_o      (tr_dpl_o),
  .done_o        (done_o),
  .status_o      (status_o),
  .null_w        (null_w)
);

// File: tb/trl_loader_test.sv
`timescale 1ns/1ps
module trl_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_sel;
  logic        busy;
  logic [15:0] glim, llim;
  logic        rd_en, tloc, wr_en;
  logic [12:0] tidx;
  logic [63:0] rd_data, wr_data;
  logic [15:0] tr_sel;
  logic [31:0] tr_base;
  logic [19:0] tr_limit;
  logic [1:0]  tr_dpl;
  logic        done;
  logic [1:0]  status;
  logic [15:0] fcode;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit tbl_init;
  bit summary_done = 0;

  logic [63:0] gtab [16];
  logic [63:0] ltab [4];

  always #4 clk = ~clk; // 125 MHz

  trl_loader uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_sel_i(req_sel), .busy_o(busy),
    .gtab_limit_i(glim), .ltab_limit_i(llim), .tbl_rd_en_o(rd_en), .tbl_local_o(tloc),
    .tbl_idx_o(tidx), .tbl_rd_data_i(rd_data), .tbl_wr_en_o(wr_en), .tbl_wr_data_o(wr_data),
    .tr_sel_o(tr_sel), .tr_base_o(tr_base), .tr_limit_o(tr_limit), .tr_dpl_o(tr_dpl),
    .done_o(done), .status_o(status), .fault_code_o(fcode)
  );

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [3:0] t, input logic s, input logic [1:0] p);
    return {b[31:24], 4'h0, l[19:16], 1'b1, p, s, t, b[23:0], l[15:0]};
  endfunction

  // table model: one-cycle read latency, single writer process
  always @(posedge clk) begin
    if (tbl_init) begin
      for (int k = 0; k < 16; k++) gtab[k] <= '0;
      for (int k = 0; k < 4; k++)  ltab[k] <= '0;
      gtab[1] <= mk(32'h12345678, 20'h00067, 4'b1001, 1'b0, 2'd0);
      gtab[2] <= mk(32'h00ABCDE0, 20'h0002B, 4'b0001, 1'b0, 2'd3);
      gtab[3] <= mk(32'h00200000, 20'h00067, 4'b1011, 1'b0, 2'd0);
      gtab[4] <= mk(32'h00000000, 20'hFFFFF, 4'b1010, 1'b1, 2'd0);
      gtab[5] <= mk(32'h00300000, 20'h00FFF, 4'b0010, 1'b0, 2'd0);
      gtab[6] <= mk(32'h00400000, 20'h00067, 4'b1001, 1'b1, 2'd0);
      ltab[2] <= mk(32'hCAFEF000, 20'hFFFFF, 4'b1001, 1'b0, 2'd2);
    end else begin
      if (rd_en) begin
        rd_cnt  <= rd_cnt + 1;
        rd_data <= tloc ? ltab[tidx[1:0]] : gtab[tidx[3:0]];
      end
      if (wr_en) begin
        wr_cnt <= wr_cnt + 1;
        if (tloc) ltab[tidx[1:0]] <= wr_data;
        else      gtab[tidx[3:0]] <= wr_data;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // issue one request, wait for its completion; lat counts edges after acceptance
  task automatic do_load(input logic [15:0] s, output logic [1:0] st, output logic [15:0] fc, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_sel   = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (lat < 20) begin
      if (done) break;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    st = status;
    fc = fcode;
    @(negedge clk);
    chk("R8", "done pulse width", {63'd0, done}, 64'd0);
  endtask

  localparam int NV = 14;
  // {selector, expected status}
  localparam logic [17:0] VEC [NV] = '{
    {16'h0000, 2'b01}, {16'h0080, 2'b01}, {16'h001C, 2'b01}, {16'h0018, 2'b11},
    {16'h0020, 2'b10}, {16'h0028, 2'b10}, {16'h0030, 2'b10}, {16'h0078, 2'b10},
    {16'h0004, 2'b10}, {16'h000B, 2'b00}, {16'h0008, 2'b11}, {16'h0010, 2'b00},
    {16'h0014, 2'b00}, {16'h0003, 2'b01}
  };

  logic [15:0] e_sel;
  logic [31:0] e_base;
  logic [19:0] e_lim;
  logic [1:0]  e_dpl;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual no completion expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [1:0]  st;
    logic [15:0] fc;
    int          lat;
    rst_n = 1'b0; req_valid = 1'b0; req_sel = '0; tbl_init = 1'b1;
    glim = 16'h007F; llim = 16'h0017;
    repeat (3) @(negedge clk);
    tbl_init = 1'b0;
    // R10 reset state
    chk("R10", "tr_sel", tr_sel, 0);
    chk("R10", "tr_base", tr_base, 0);
    chk("R10", "done", done, 0);
    chk("R10", "busy", busy, 0);
    rst_n = 1'b1;
    e_sel = '0; e_base = '0; e_lim = '0; e_dpl = '0;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] s;
      logic [1:0]  es;
      logic [63:0] ent;
      int          r0, w0, elat;
      s  = VEC[i][17:2];
      es = VEC[i][1:0];
      ent = '0;
      if (es != 2'b01) ent = s[2] ? ltab[s[4:3]] : gtab[s[6:3]];
      r0 = rd_cnt; w0 = wr_cnt;
      elat = (es == 2'b01) ? 1 : ((es == 2'b00) ? 4 : 3);
      do_load(s, st, fc, lat);
      case (es)
        2'b01: begin chk("R2", "status", st, es); chk("R2", "latency", lat, elat);
                     chk("R2", "reads", rd_cnt - r0, 0); end
        2'b10: begin chk("R3", "status", st, es); chk("R3", "latency", lat, elat);
                     chk("R1", "reads", rd_cnt - r0, 1); end
        2'b11: begin chk("R4", "status", st, es); chk("R4", "latency", lat, elat); end
        default: begin
          chk("R5", "status", st, es); chk("R5", "latency", lat, elat);
          e_sel = s; e_base = {ent[63:56], ent[39:16]}; e_lim = {ent[51:48], ent[15:0]}; e_dpl = ent[46:45];
          chk("R6", "written entry", s[2] ? ltab[s[4:3]] : gtab[s[6:3]], ent | (64'd1 << 41));
          chk("R6", "writes", wr_cnt - w0, 1);
        end
      endcase
      if (es != 2'b00) begin
        chk("R7", "writes on fault", wr_cnt - w0, 0);
        chk("R8", "fault code", fc, s & 16'hFFFC);
      end else begin
        chk("R8", "fault code ok", fc, 0);
      end
      chk(es == 2'b00 ? "R5" : "R7", "tr_sel", tr_sel, e_sel);
      chk(es == 2'b00 ? "R5" : "R7", "tr_base", tr_base, e_base);
      chk(es == 2'b00 ? "R5" : "R7", "tr_limit", tr_limit, e_lim);
      chk(es == 2'b00 ? "R5" : "R7", "tr_dpl", tr_dpl, e_dpl);
    end

    // fresh start for directed tests
    @(negedge clk);
    rst_n = 1'b0; tbl_init = 1'b1;
    repeat (2) @(negedge clk);
    tbl_init = 1'b0;
    chk("R10", "tr_sel after re-reset", tr_sel, 0);
    rst_n = 1'b1;

    // R9: second request held through every busy cycle, including the write-back cycle
    begin
      int w0, dn;
      w0 = wr_cnt;
      @(negedge clk); req_valid = 1'b1; req_sel = 16'h000B;
      @(posedge clk);
      @(negedge clk); req_sel = 16'h0010;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      chk("R9", "write-back cycle busy", {62'd0, busy, wr_en}, 64'd3);
      @(posedge clk);
      @(negedge clk); req_valid = 1'b0;
      chk("R9", "done after held request", done, 1);
      chk("R5", "status", status, 0);
      chk("R9", "tr_sel keeps first", tr_sel, 16'h000B);
      dn = 0;
      repeat (6) begin @(negedge clk); if (done) dn++; end
      chk("R9", "extra completions", dn, 0);
      chk("R9", "ignored entry untouched", gtab[2][43:40], 4'b0001);
      chk("R9", "single write", wr_cnt - w0, 1);
    end

    // write-back must be visible to an immediate reload
    do_load(16'h000B, st, fc, lat);
    chk("R4", "reload of just-loaded", st, 2'b11);
    chk("R8", "busy fault code", fc, 16'h0008);
    do_load(16'h0010, st, fc, lat);
    chk("R5", "previously ignored selector", st, 2'b00);
    chk("R5", "tr_dpl", tr_dpl, 2'd3);

    // R2 local limit boundary: last byte 0x17 just past limit 0x16
    llim = 16'h0016;
    do_load(16'h0014, st, fc, lat);
    chk("R2", "local limit edge", st, 2'b01);
    chk("R7", "tr_sel kept", tr_sel, 16'h0010);
    llim = 16'h0017;
    do_load(16'h0014, st, fc, lat);
    chk("R2", "local limit exact", st, 2'b00);
    chk("R5", "local base", tr_base, 32'hCAFEF000);

    summary();
    $finish;
  end
endmodule